// File: doc/BRIEF.md
# Set-Bit Position Compactor

This block turns a 16-bit flag word into a dense list of the indices of its set bits. Each index is a 4-bit value. Sixteen such values sit side by side in a 64-bit output, and each one can act as the select of a 16-to-1 multiplexer. A typical use is a switch stage, where slot k of the list picks the source lane for destination k. The list starts at slot 0 with the lowest set bit and rises from there, with no empty slots between valid entries. Every slot at or above the population count holds zero. The population count is delivered alongside the list.

The block is fully pipelined. It can take a new word on every clock, and each result leaves three register stages later. The first stage packs each quarter of the word on its own. The second stage joins neighbouring quarters into halves. The third stage joins the two halves. Each join is a shallow select steered by the count of the lower part, so no single stage carries a long chain of multiplexers. A valid flag travels with each word. When no valid word is in flight, the outputs keep the last result.

Top module: `bitPosCompactor`

## Requirements
- R1: One word is accepted on every rising edge where `inValid` is high. A run of N back-to-back valid words yields N back-to-back results with `outValid` high.
- R2: A word sampled with `inValid` high produces `outValid` high after the third rising edge, counting the sampling edge as the first. A word sampled with `inValid` low produces `outValid` low at that same point.
- R3: Slot k of `outSel` occupies bits [4k+3:4k]. Slot 0 holds the lowest set bit index, and the slots below `outCount` hold strictly increasing indices.
- R4: Every slot k with k >= `outCount` reads 0. This holds, for example, for input 16'h0001, where only slot 0 is in use and its value is 0.
- R5: `outCount` equals the number of set bits in the word (0 to 16). It is aligned to the same result as `outSel`.
- R6: An all-zero word gives `outCount` = 0, `outSel` = 0 and `outValid` = 1.
- R7: An all-ones word gives `outCount` = 16 and `outSel` = 64'hFEDCBA9876543210, which is indices 0 to 15 in slots 0 to 15.
- R8: A synchronous reset clears every valid flag and every pipeline register. On the edge after reset is sampled, `outValid`, `outCount` and `outSel` read 0.
- R9: While `outValid` is low, `outSel` and `outCount` keep the values of the last result, or of reset if no result has been produced since.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Qualifies `inWord` in this cycle |
| inWord | input | 16 | Flag word whose set-bit indices are listed |
| outValid | output | 1 | A new result is present on the outputs |
| outCount | output | 5 | Number of set bits in the result's word |
| outSel | output | 64 | Sixteen 4-bit index slots, slot 0 in the low bits |

## Verification
The bound checker watches four behaviours on every cycle. It checks the three-edge valid latency. It checks the population count against the word delayed by three cycles. It checks the zero tail above the count and the strictly rising order of the used slots. It also checks that the outputs hold while no result is valid, and that they are cleared after reset. The exact index values in each slot, the all-zero and all-ones corner words, and unbroken throughput across a long burst can only be shown by the bench. It compares every result against a model computed from the word it drove.

// File: rtl/bpcPkg.sv
`timescale 1ns/1ps
package bpcPkg;
  // Strobes the control module hands to the datapath each cycle.
  typedef struct packed {
    logic clear;   // synchronous clear of every pipeline register
    logic load1;   // quarter-packed lists enter stage 1
    logic load2;   // merged halves enter stage 2
    logic load3;   // full list enters the output stage
  } stageStrobe_t;
endpackage

// File: rtl/bpcGroupPack.sv
`timescale 1ns/1ps
// Packs the set-bit indices of one GRP-bit slice into ascending slots.
module bpcGroupPack #(
  parameter int GRP   = 4,
  parameter int IDX_W = 4,
  parameter int CNT_W = 5,
  parameter int BASE  = 0
) (
  input  logic [GRP-1:0]            bits,
  output logic [GRP-1:0][IDX_W-1:0] fields,
  output logic [CNT_W-1:0]          cnt
);
  localparam int SEL_W  = $clog2(GRP);
  localparam int LCNT_W = $clog2(GRP + 1);

  logic [GRP-1:0][IDX_W-1:0] packF;
  logic [LCNT_W-1:0]         run;

  always_comb begin
    packF = '0;
    run   = '0;
    for (int b = 0; b < GRP; b++) begin
      if (bits[b]) begin
        packF[run[SEL_W-1:0]] = IDX_W'(BASE + b);
        run = run + 1'b1;
      end
    end
  end

  assign fields = packF;
  assign cnt    = CNT_W'(run);
endmodule

// File: rtl/bpcMerge.sv
`timescale 1ns/1ps
// Joins a lower and an upper packed list; the upper list is shifted down
// by the lower count so no empty slot remains between them.
module bpcMerge #(
  parameter int GRP   = 4,
  parameter int IDX_W = 4,
  parameter int CNT_W = 5
) (
  input  logic [GRP-1:0][IDX_W-1:0]   loF,
  input  logic [CNT_W-1:0]            loCnt,
  input  logic [GRP-1:0][IDX_W-1:0]   hiF,
  input  logic [CNT_W-1:0]            hiCnt,
  output logic [2*GRP-1:0][IDX_W-1:0] mergedF,
  output logic [CNT_W-1:0]            mergedCnt
);
  localparam int SEL_W = $clog2(GRP);

  for (genvar i = 0; i < 2*GRP; i++) begin : gSlot
    localparam bit LO_OK  = (i < GRP);
    localparam int LO_IDX = (i < GRP) ? i : 0;
    logic [IDX_W-1:0] pick;

    always_comb begin
      pick = '0;
      for (int k = 0; k < GRP; k++) begin
        if (CNT_W'(k) + loCnt == CNT_W'(i)) pick = hiF[k[SEL_W-1:0]];
      end
      if (LO_OK && (CNT_W'(i) < loCnt)) pick = loF[LO_IDX];
    end

    assign mergedF[i] = pick;
  end

  assign mergedCnt = loCnt + hiCnt;
endmodule

// File: rtl/bpcControl.sv
`timescale 1ns/1ps
// Valid pipeline and the strobes that steer the datapath registers.
module bpcControl import bpcPkg::*; (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output stageStrobe_t strobe,
  output logic         outValid
);
  logic validS1, validS2, validS3;

  always_ff @(posedge clk) begin
    if (rst) begin
      validS1 <= 1'b0;
      validS2 <= 1'b0;
      validS3 <= 1'b0;
    end else begin
      validS1 <= inValid;
      validS2 <= validS1;
      validS3 <= validS2;
    end
  end

  always_comb begin
    strobe.clear = rst;
    strobe.load1 = inValid;
    strobe.load2 = validS1;
    strobe.load3 = validS2;
  end

  assign outValid = validS3;
endmodule

// File: rtl/bpcDatapath.sv
`timescale 1ns/1ps
// Three register stages: quarter packing, half merge, full merge.
module bpcDatapath import bpcPkg::*; #(
  parameter int WORD_W = 16,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 5
) (
  input  logic                     clk,
  input  stageStrobe_t             strobe,
  input  logic [WORD_W-1:0]        inWord,
  output logic [WORD_W*IDX_W-1:0]  outSel,
  output logic [CNT_W-1:0]         outCount
);
  localparam int PARTS = 4;
  localparam int Q     = WORD_W / PARTS;
  localparam int H     = 2 * Q;

  // Stage 1: each quarter packed independently
  logic [Q-1:0][IDX_W-1:0] partF   [PARTS];
  logic [CNT_W-1:0]        partCnt [PARTS];
  logic [Q-1:0][IDX_W-1:0] s1F     [PARTS];
  logic [CNT_W-1:0]        s1Cnt   [PARTS];

  for (genvar p = 0; p < PARTS; p++) begin : gPart
    bpcGroupPack #(.GRP(Q), .IDX_W(IDX_W), .CNT_W(CNT_W), .BASE(p*Q)) uPack (
      .bits   (inWord[p*Q +: Q]),
      .fields (partF[p]),
      .cnt    (partCnt[p])
    );
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      for (int p = 0; p < PARTS; p++) begin
        s1F[p]   <= '0;
        s1Cnt[p] <= '0;
      end
    end else if (strobe.load1) begin
      s1F   <= partF;
      s1Cnt <= partCnt;
    end
  end

  // Stage 2: neighbouring quarters merged into halves
  logic [H-1:0][IDX_W-1:0] halfF   [2];
  logic [CNT_W-1:0]        halfCnt [2];
  logic [H-1:0][IDX_W-1:0] s2F     [2];
  logic [CNT_W-1:0]        s2Cnt   [2];

  for (genvar h = 0; h < 2; h++) begin : gHalf
    bpcMerge #(.GRP(Q), .IDX_W(IDX_W), .CNT_W(CNT_W)) uJoin (
      .loF       (s1F[2*h]),
      .loCnt     (s1Cnt[2*h]),
      .hiF       (s1F[2*h+1]),
      .hiCnt     (s1Cnt[2*h+1]),
      .mergedF   (halfF[h]),
      .mergedCnt (halfCnt[h])
    );
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      for (int h = 0; h < 2; h++) begin
        s2F[h]   <= '0;
        s2Cnt[h] <= '0;
      end
    end else if (strobe.load2) begin
      s2F   <= halfF;
      s2Cnt <= halfCnt;
    end
  end

  // Stage 3: halves merged into the full list
  logic [WORD_W-1:0][IDX_W-1:0] fullF, s3F;
  logic [CNT_W-1:0]             fullCnt, s3Cnt;

  bpcMerge #(.GRP(H), .IDX_W(IDX_W), .CNT_W(CNT_W)) uFinal (
    .loF       (s2F[0]),
    .loCnt     (s2Cnt[0]),
    .hiF       (s2F[1]),
    .hiCnt     (s2Cnt[1]),
    .mergedF   (fullF),
    .mergedCnt (fullCnt)
  );

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      s3F   <= '0;
      s3Cnt <= '0;
    end else if (strobe.load3) begin
      s3F   <= fullF;
      s3Cnt <= fullCnt;
    end
  end

  assign outSel   = s3F;
  assign outCount = s3Cnt;
endmodule

// File: rtl/bitPosCompactor.sv
`timescale 1ns/1ps
// Top: WORD_W must be a power of two, at least 8.
module bitPosCompactor import bpcPkg::*; #(
  parameter  int WORD_W = 16,
  localparam int IDX_W  = $clog2(WORD_W),
  localparam int CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic [WORD_W-1:0]       inWord,
  output logic                    outValid,
  output logic [CNT_W-1:0]        outCount,
  output logic [WORD_W*IDX_W-1:0] outSel
);
  stageStrobe_t strobe;

  bpcControl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  bpcDatapath #(.WORD_W(WORD_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) uData (
    .clk      (clk),
    .strobe   (strobe),
    .inWord   (inWord),
    .outSel   (outSel),
    .outCount (outCount)
  );
endmodule

// File: rtl/bpcChecker.sv
`timescale 1ns/1ps
module bpcChecker #(
  parameter int WORD_W = 16,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 5
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    inValid,
  input logic [WORD_W-1:0]       inWord,
  input logic                    outValid,
  input logic [CNT_W-1:0]        outCount,
  input logic [WORD_W*IDX_W-1:0] outSel
);
  // cycles since reset, saturating at the pipeline depth
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> (outValid == $past(inValid, 3)));

  assert_count_match_R5: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && outValid) |-> (outCount == CNT_W'($countones($past(inWord, 3)))));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd0 && !outValid) |-> ($stable(outSel) && $stable(outCount)));

  assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && outCount == '0 && outSel == '0));

  for (genvar k = 0; k < WORD_W; k++) begin : gTail
    assert_zero_tail_R4: assert property (@(posedge clk) disable iff (rst)
      (outValid && outCount <= CNT_W'(k)) |-> (outSel[k*IDX_W +: IDX_W] == '0));
  end

  for (genvar k = 0; k < WORD_W - 1; k++) begin : gOrder
    assert_ascending_R3: assert property (@(posedge clk) disable iff (rst)
      (outValid && CNT_W'(k + 1) < outCount) |->
        (outSel[k*IDX_W +: IDX_W] < outSel[(k+1)*IDX_W +: IDX_W]));
  end
endmodule

bind bitPosCompactor bpcChecker #(.WORD_W(WORD_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rst(rst), .inValid(inValid), .inWord(inWord),
  .outValid(outValid), .outCount(outCount), .outSel(outSel)
);

// File: tb/sim_bitPosCompactor.sv
`timescale 1ns/1ps
module sim_bitPosCompactor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [15:0] inWord = '0;
  logic        outValid;
  logic [4:0]  outCount;
  logic [63:0] outSel;

  bitPosCompactor u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inWord(inWord),
    .outValid(outValid), .outCount(outCount), .outSel(outSel)
  );

  always #2.5 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  int    t      = 0;
  int    r1Seen = 0;
  logic        hV [4];
  logic [15:0] hW [4];
  string       hTag [4];
  logic [63:0] lastSel;
  logic [4:0]  lastCnt;

  function automatic logic [63:0] modelSel(logic [15:0] w);
    logic [63:0] r = '0;
    int n = 0;
    for (int b = 0; b < 16; b++) begin
      if (w[b]) begin
        r[n*4 +: 4] = b[3:0];
        n++;
      end
    end
    return r;
  endfunction

  function automatic logic [4:0] modelCnt(logic [15:0] w);
    int n = 0;
    for (int b = 0; b < 16; b++) if (w[b]) n++;
    return n[4:0];
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearHistory();
    for (int i = 0; i < 4; i++) begin
      hV[i] = 1'b0; hW[i] = '0; hTag[i] = "R9";
    end
    lastSel = '0;
    lastCnt = '0;
  endtask

  // One cycle: check what the word from three steps ago produced, then drive.
  task automatic step(logic v, logic [15:0] w, string tag);
    int o;
    @(negedge clk);
    o = (t + 1) % 4;
    check("R2 outValid", {63'd0, outValid}, {63'd0, hV[o]});
    if (hV[o]) begin
      lastSel = modelSel(hW[o]);
      lastCnt = modelCnt(hW[o]);
      check({hTag[o], " outSel"}, outSel, lastSel);
      check("R5 outCount", {59'd0, outCount}, {59'd0, lastCnt});
      if (hTag[o] == "R1" && outValid) r1Seen++;
    end else begin
      check("R9 held outSel", outSel, lastSel);
      check("R9 held outCount", {59'd0, outCount}, {59'd0, lastCnt});
    end
    hV[t % 4] = v; hW[t % 4] = w; hTag[t % 4] = tag;
    inValid = v;
    inWord  = w;
    t++;
  endtask

  task automatic doReset();
    rst = 1'b1;
    inValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8 outValid", {63'd0, outValid}, 64'd0);
    check("R8 outCount", {59'd0, outCount}, 64'd0);
    check("R8 outSel", outSel, 64'd0);
    clearHistory();
    rst = 1'b0;
  endtask

  function automatic logic [15:0] randWord();
    logic [15:0] a = 16'($urandom);
    logic [15:0] b = 16'($urandom);
    case ($urandom % 4)
      0: return a & b;        // sparse
      1: return a | b;        // dense
      2: return 16'(1) << ($urandom % 16);
      default: return a;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd424242));
    clearHistory();
    doReset();
    // directed corners
    step(1'b1, 16'h0000, "R6");
    step(1'b1, 16'hFFFF, "R7");
    step(1'b1, 16'h8001, "R3");
    step(1'b1, 16'h0001, "R4");
    step(1'b1, 16'h8000, "R4");
    step(1'b1, 16'hAAAA, "R3");
    // idle words must not disturb outputs
    for (int i = 0; i < 5; i++) step(1'b0, randWord(), "R9");
    // unbroken burst
    for (int i = 0; i < 40; i++) step(1'b1, randWord(), "R1");
    for (int i = 0; i < 4; i++) step(1'b0, 16'hFFFF, "R9");
    check("R1 burst results", 64'(r1Seen), 64'd40);
    // random mix
    for (int i = 0; i < 300; i++) step(($urandom % 4) != 0, randWord(), "R3/R4");
    // reset with words in flight
    step(1'b1, 16'h1234, "R8");
    step(1'b1, 16'hF0F0, "R8");
    doReset();
    step(1'b1, 16'hFFFF, "R7");
    step(1'b1, 16'h0000, "R6");
    for (int i = 0; i < 5; i++) step(1'b0, 16'h0000, "R9");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule